// File: doc/BRIEF.md
# Glitch-Free Bypass Clock Selector

This block produces the bypass reference clock of a display clock generator from two legs. The primary leg takes a reference clock and divides it by N2+1, where N2 is a programmable input; with N2 equal to zero the reference passes through unchanged. The alternate low-power leg carries one of two upstream clocks, picked by its own select. A leg select then chooses which leg drives the output, and an output enable gates the chosen clock before it leaves the block.

Both selections are made glitch-free by the same scheme. Each candidate clock has its own short synchronizer chain, clocked by that candidate, which only starts when the competing candidate is disabled. The final enable stage of each chain updates on the falling edge of its own clock. A candidate is therefore removed only after it has finished a high phase, and it is added only while it is low. The output gate follows the same rule: it synchronizes the enable to the selected clock and updates the gate on that clock's falling edge. Select and divide values are plain inputs, normally driven from a control register that resets to zero.

Top module: `bypclk_sel`

## Requirements
- R1: While `rstN` is low, `bypClk` is held low. After reset is released with `legSel` = 0 and `outEn` = 1, `bypClk` follows the primary leg.
- R2: With `legSel` = 0, `bypClk` has the period of the divided reference. With `legSel` = 1, it has the period of the alternate leg.
- R3: The two legs are never enabled at the same time. No high or low phase of `bypClk` is ever shorter than the shortest half-period of the source clocks, including phases that span a select change.
- R4: The primary leg divides `refClk` by `divN2`+1 for every value of `divN2`, up to the all-ones value. `divN2` = 0 passes `refClk` through undivided.
- R5: For `divN2` >= 1, the divided clock is high for floor((`divN2`+1)/2) reference cycles in each period and low for the remaining cycles. For `divN2` = 0, its waveform is that of `refClk`.
- R6: The alternate leg carries `altClkA` when `altSel` = 0 and `altClkB` when `altSel` = 1. The change between them is glitch-free, and at most one of the two is enabled at any time.
- R7: With `outEn` = 0, `bypClk` stays low and shows no rising edge once the enable has passed the gate synchronizer. Raising `outEn` again restores the selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Primary reference clock, input of the divider |
| altClkA | input | 1 | First candidate for the alternate leg |
| altClkB | input | 1 | Second candidate for the alternate leg |
| rstN | input | 1 | Asynchronous active-low reset |
| divN2 | input | DIV_W | Divide value; the ratio is `divN2`+1 |
| legSel | input | 1 | 0 selects the divided primary leg, 1 the alternate leg |
| altSel | input | 1 | 0 selects `altClkA`, 1 selects `altClkB` for the alternate leg |
| outEn | input | 1 | Output clock enable |
| bypClk | output | 1 | Gated bypass clock |

## Verification
The assertions take four things for granted about the inputs. A select is held stable until the handover it started has finished, which takes a few cycles of both the outgoing and the incoming clock. The two selects never change together. `divN2` changes only while the alternate leg drives the output. The source clocks keep running. Under these conditions the interlock never admits both legs, and a newly enabled leg always matches the select. In the random phase the bench therefore holds every select for at least 150 ns, keeps `divN2` at 3 or below, and changes `divN2` only while `legSel` is 1. Throughout the run it times every output phase against the 2 ns shortest half-period.

// File: rtl/bypclk_pkg.sv
`timescale 1ns/1ps
package bypclk_pkg;
  // enable strobes handed from the control module to the datapath
  typedef struct packed {
    logic altEnA;
    logic altEnB;
    logic legEn0;
    logic legEn1;
  } bypclk_en_t;

  localparam int unsigned NUM_CAND = 4;
endpackage

// File: rtl/bypclk_gfsync.sv
`timescale 1ns/1ps
// One candidate of a glitch-free switch: a lockout-qualified synchronizer on
// the rising edge, and an enable that moves only on the falling edge.
module bypclk_gfsync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic want,
  input  logic otherEn,
  output logic en
);
  logic [SYNC_LEN-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= want & ~otherEn;
      for (int i = 1; i < SYNC_LEN; i++) chain[i] <= chain[i-1];
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) en <= 1'b0;
    else       en <= chain[SYNC_LEN-1];
  end
endmodule

// File: rtl/bypclk_ctrl.sv
`timescale 1ns/1ps
module bypclk_ctrl
  import bypclk_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic       altClkA,
  input  logic       altClkB,
  input  logic       divClk,
  input  logic       altClk,
  input  logic       rstN,
  input  logic       legSel,
  input  logic       altSel,
  output bypclk_en_t en
);
  // candidates 0/1 form the alternate pre-select pair, 2/3 the leg pair
  logic [NUM_CAND-1:0] candClk;
  logic [NUM_CAND-1:0] candWant;
  logic [NUM_CAND-1:0] candEn;

  assign candClk  = {altClk, divClk, altClkB, altClkA};
  assign candWant = {legSel, ~legSel, altSel, ~altSel};

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_cand
    bypclk_gfsync #(.SYNC_LEN(SYNC_LEN)) u_sync (
      .clk    (candClk[i]),
      .rstN   (rstN),
      .want   (candWant[i]),
      .otherEn(candEn[i ^ 1]),
      .en     (candEn[i])
    );
  end

  assign en.altEnA = candEn[0];
  assign en.altEnB = candEn[1];
  assign en.legEn0 = candEn[2];
  assign en.legEn1 = candEn[3];

  AST_ALT_ONEHOT: assert property (@(posedge altClkA) disable iff (!rstN)
    $onehot0({en.altEnA, en.altEnB})); // R6
endmodule

// File: rtl/bypclk_data.sv
`timescale 1ns/1ps
module bypclk_data
  import bypclk_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic             refClk,
  input  logic             altClkA,
  input  logic             altClkB,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divN2,
  input  logic             legSel,
  input  logic             outEn,
  input  bypclk_en_t       en,
  output logic             divClk,
  output logic             altClk,
  output logic             bypClk
);
  logic [DIV_W-1:0]    cnt;
  logic [DIV_W-1:0]    cntNext;
  logic [DIV_W:0]      hiCnt;
  logic                divQ;
  logic                muxClk;
  logic [SYNC_LEN-1:0] gateChain;
  logic                gateEn;

  // divide-by-(N2+1): counter wraps at divN2, output high for the first half
  always_comb begin
    cntNext = (cnt >= divN2) ? '0 : cnt + 1'b1;
    hiCnt   = ({1'b0, divN2} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      divQ <= 1'b0;
    end else begin
      cnt  <= cntNext;
      divQ <= ({1'b0, cntNext} < hiCnt);
    end
  end

  assign divClk = (divN2 == '0) ? refClk : divQ;
  assign altClk = (altClkA & en.altEnA) | (altClkB & en.altEnB);
  assign muxClk = (divClk & en.legEn0) | (altClk & en.legEn1);

  // output gate: enable synchronized, then applied on the falling edge
  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      gateChain <= '0;
    end else begin
      gateChain[0] <= outEn;
      for (int i = 1; i < SYNC_LEN; i++) gateChain[i] <= gateChain[i-1];
    end
  end

  always_ff @(negedge muxClk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= gateChain[SYNC_LEN-1];
  end

  assign bypClk = muxClk & gateEn;

  AST_DIV_WRAP: assert property (@(posedge refClk) disable iff (!rstN)
    (cnt >= divN2) |=> (cnt == '0)); // R4
  AST_LEG_ONEHOT: assert property (@(posedge refClk) disable iff (!rstN)
    $onehot0({en.legEn0, en.legEn1})); // R3
  AST_LEG1_MATCH: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(en.legEn1) |-> legSel); // R2
  AST_LEG0_MATCH: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(en.legEn0) |-> !legSel); // R2
endmodule

// File: rtl/bypclk_sel.sv
`timescale 1ns/1ps
module bypclk_sel
  import bypclk_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic             refClk,
  input  logic             altClkA,
  input  logic             altClkB,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divN2,
  input  logic             legSel,
  input  logic             altSel,
  input  logic             outEn,
  output logic             bypClk
);
  bypclk_en_t enStrobe;
  logic       divClk;
  logic       altClk;

  bypclk_ctrl #(.SYNC_LEN(SYNC_LEN)) u_ctrl (
    .altClkA(altClkA),
    .altClkB(altClkB),
    .divClk (divClk),
    .altClk (altClk),
    .rstN   (rstN),
    .legSel (legSel),
    .altSel (altSel),
    .en     (enStrobe)
  );

  bypclk_data #(.DIV_W(DIV_W), .SYNC_LEN(SYNC_LEN)) u_data (
    .refClk (refClk),
    .altClkA(altClkA),
    .altClkB(altClkB),
    .rstN   (rstN),
    .divN2  (divN2),
    .legSel (legSel),
    .outEn  (outEn),
    .en     (enStrobe),
    .divClk (divClk),
    .altClk (altClk),
    .bypClk (bypClk)
  );
endmodule

// File: tb/bypclk_sel_tb.sv
`timescale 1ns/1ps
module bypclk_sel_tb;
  localparam int  DIV_W    = 4;
  localparam real REF_HALF = 2.0;
  localparam real A_HALF   = 3.5;
  localparam real B_HALF   = 5.0;
  localparam real MIN_HALF = 2.0;

  logic             refClk  = 1'b0;
  logic             altClkA = 1'b0;
  logic             altClkB = 1'b0;
  logic             rstN    = 1'b0;
  logic [DIV_W-1:0] divN2   = '0;
  logic             legSel  = 1'b0;
  logic             altSel  = 1'b0;
  logic             outEn   = 1'b1;
  logic             bypClk;

  int      checks    = 0;
  int      fails     = 0;
  int      riseCount = 0;
  int      phaseViol = 0;
  bit      phaseOn   = 1'b0;
  bit      done      = 1'b0;
  realtime lastEdge  = -1000.0;
  realtime lastRise  = -1000.0;
  realtime prevRise  = -1000.0;

  always #(REF_HALF) refClk  = ~refClk;   // 250 MHz
  always #(A_HALF)   altClkA = ~altClkA;
  always #(B_HALF)   altClkB = ~altClkB;

  bypclk_sel #(.DIV_W(DIV_W)) u_dut (
    .refClk (refClk),
    .altClkA(altClkA),
    .altClkB(altClkB),
    .rstN   (rstN),
    .divN2  (divN2),
    .legSel (legSel),
    .altSel (altSel),
    .outEn  (outEn),
    .bypClk (bypClk)
  );

  // behavioural observers of the output waveform
  always @(posedge bypClk) begin
    prevRise = lastRise;
    lastRise = $realtime;
    riseCount++;
  end

  always @(bypClk) begin
    if (phaseOn && ($realtime - lastEdge < MIN_HALF - 0.01)) begin
      phaseViol++;
      $display("[TB] short phase of %0.3f ns at %0.3f", $realtime - lastEdge, $realtime);
    end
    lastEdge = $realtime;
  end

  function automatic bit near(real a, real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  task automatic check(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  // reference model: period and high time of the selected source
  function automatic real refPeriod(int n2);
    return 2.0 * REF_HALF * (n2 + 1);
  endfunction

  function automatic real refHigh(int n2);
    if (n2 == 0) return REF_HALF;
    return 2.0 * REF_HALF * ((n2 + 1) / 2);
  endfunction

  task automatic measure(output real per, output real hi);
    @(posedge bypClk);
    @(negedge bypClk);
    hi = $realtime - lastRise;
    @(posedge bypClk);
    #0.01;
    per = lastRise - prevRise;
  endtask

  task automatic expectWave(string req, real expPer, real expHi);
    real per, hi;
    #400;
    measure(per, hi);
    check(near(per, expPer), req, "period", per, expPer);
    check(near(hi, expHi), req, "high time", hi, expHi);
  endtask

  // divide value is only changed while the alternate leg drives the output
  task automatic setDiv(int n2);
    legSel = 1'b1;
    #400;
    divN2 = n2[DIV_W-1:0];
    #100;
    legSel = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    int c0;
    #10.3;
    // R1: quiet while reset is held
    check(bypClk == 1'b0, "R1", "output during reset", bypClk, 0);
    check(riseCount == 0, "R1", "rises during reset", riseCount, 0);
    #10;
    rstN    = 1'b1;
    phaseOn = 1'b1;

    // R1 R4 R5: primary leg, undivided
    expectWave("R1", refPeriod(0), refHigh(0));

    // R4 R5: a spread of divide values, odd and even ratios, and the top value
    for (int n = 1; n <= 4; n++) begin
      setDiv(n);
      expectWave((n % 2 == 0) ? "R5" : "R4", refPeriod(n), refHigh(n));
    end
    setDiv(15);
    expectWave("R4", refPeriod(15), refHigh(15));
    setDiv(2);
    expectWave("R5", refPeriod(2), refHigh(2));

    // R2 R6: alternate leg with each candidate
    legSel = 1'b1;
    expectWave("R2", 2.0 * A_HALF, A_HALF);
    altSel = 1'b1;
    expectWave("R6", 2.0 * B_HALF, B_HALF);
    altSel = 1'b0;
    expectWave("R6", 2.0 * A_HALF, A_HALF);

    // R7: output enable gate
    outEn = 1'b0;
    #400;
    c0 = riseCount;
    #500;
    check(riseCount == c0, "R7", "rises while disabled", riseCount - c0, 0);
    check(bypClk == 1'b0, "R7", "level while disabled", bypClk, 0);
    outEn = 1'b1;
    expectWave("R7", 2.0 * A_HALF, A_HALF);

    // R3: random select, enable and divide changes with settle holds
    for (int it = 0; it < 150; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5)                  legSel = ~legSel;
      else if (r < 8)             altSel = ~altSel;
      else if (r == 9 && legSel)  divN2  = DIV_W'($urandom_range(0, 3));
      else                        outEn  = ~outEn;
      #($urandom_range(150, 400));
    end

    outEn  = 1'b1;
    legSel = 1'b1;
    #400;
    divN2  = 3;
    #100;
    legSel = 1'b0;
    expectWave("R2", refPeriod(3), refHigh(3));
    check(phaseViol == 0, "R3", "short output phases", phaseViol, 0);
    finishRun();
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end
endmodule